// File: doc/BRIEF.md
# I2C Memory-Read Target

This block is an I2C target that fronts two small byte stores: a 64-byte general-purpose array and a smaller identity array. The master picks one of them through the 7-bit code in the control byte, and the low bit of that byte gives the direction. A single pointer is kept across transactions. A write transaction loads the pointer, and any later read starts from it.

Three read flows are served from that pointer. A current-address read returns the byte at the pointer. A random read is a write that carries only a word address, then a repeated Start and a read control byte. A sequential read continues as long as the master acknowledges each byte. Every completed byte access advances the pointer, which wraps inside the selected array. Data bytes that follow the word address in a write are stored, which makes it easy to fill the arrays.

SCL and SDA arrive synchronous to the core clock. The block drives SDA only through an open-drain enable that pulls the line low.

Top module: `i2c_mem_target`

## Requirements
- R1: While rst_ni is low, sda_oe_o is 0 and the pointer is cleared to 0. Array contents are not reset, so the first current-address read after reset returns the byte at address 0.
- R2: A control byte whose upper 7 bits are 1101111 selects the 64-byte array, and 1010111 selects the identity array. Either one is acknowledged by pulling SDA low during the ninth clock. Any other code is not acknowledged, SDA stays released and the transaction is ignored until the next Start.
- R3: In a write (control byte bit 0 = 0), a word address below the selected array's depth is acknowledged and loads the pointer. Each following data byte is acknowledged, stored at the pointer, and advances the pointer.
- R4: A word address at or above the selected array's depth is not acknowledged. It leaves the pointer unchanged, and the rest of the transaction is ignored.
- R5: A read control byte (bit 0 = 1) is acknowledged, then the byte at the pointer is sent MSB first. The pointer advances once the byte completes.
- R6: A random read (word-address write, repeated Start, read control byte) returns the byte at that address. Afterwards the pointer holds the address plus one.
- R7: In a read, a master ACK (SDA low in the ninth clock) makes the target send the next byte. A master NACK ends the transfer with SDA released.
- R8: The pointer wraps from the last address of the selected array to 0: from 63 in the 64-byte array and from 7 in the identity array.
- R9: SDA is sampled on SCL rising edges, and sda_oe_o changes only while SCL is low, except when a Start or Stop releases it.
- R10: A Start seen at any time, including mid-byte, aborts the current transfer and begins a new control byte. A Stop returns the target to idle. A partially received byte is never stored.
- R11: The two arrays hold separate contents, so the same address gives independent data depending on the control code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock, synchronous to clk_i |
| sda_i | input | 1 | I2C data line level, synchronous to clk_i |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a well-behaved master. SDA may change only while SCL is low, except when the master forms a Start or Stop. The master never issues a Start or Stop while the target is holding SDA low. Each SCL level also lasts several core clocks, so every edge is seen as a separate event. The bench drives the bus through tasks that hold each SCL phase for four core clocks and move SDA only during the low phase or inside the Start and Stop tasks. Aborts are placed only in bits where the master owns SDA.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam logic [6:0] CODE_GP = 7'b1101111;
  localparam logic [6:0] CODE_ID = 7'b1010111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACK_CTRL,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_bank.sv
module i2c_byte_bank #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [AW-1:0] wrap_mask_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= (ptr_q + 1'b1) & wrap_mask_i;
  end

  assign ptr_o = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && ptr_q == wrap_mask_i) |=> (ptr_q == '0)); // R8
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int GP_DEPTH = 64,
  parameter int ID_DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2c_tgt_pkg::*;

  localparam int AW  = $clog2(GP_DEPTH);
  localparam int IAW = $clog2(ID_DEPTH);
  localparam logic [AW-1:0] GP_MASK = AW'(GP_DEPTH - 1);
  localparam logic [AW-1:0] ID_MASK = AW'(ID_DEPTH - 1);
  localparam logic [8:0]    GP_LIM  = 9'(GP_DEPTH);
  localparam logic [8:0]    ID_LIM  = 9'(ID_DEPTH);

  tgt_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sr_q, tx_q;
  logic       oe_q, rw_q, rgn_q; // rgn_q: 1 = identity array

  logic rise_w, fall_w, start_w, stop_w;
  logic byte_end, code_hit, id_hit, addr_ok;
  logic wr_fire, rd_done, ptr_load;
  logic [AW-1:0] ptr_w, mask_w;
  logic [7:0] gp_rd, id_rd, rd_byte;

  i2c_bus_cond u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .rise_o  (rise_w),
    .fall_o  (fall_w),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  assign byte_end = (cnt_q == 4'd8);
  assign id_hit   = (sr_q[7:1] == CODE_ID);
  assign code_hit = id_hit || (sr_q[7:1] == CODE_GP);
  assign addr_ok  = rgn_q ? ({1'b0, sr_q} < ID_LIM) : ({1'b0, sr_q} < GP_LIM);
  assign mask_w   = rgn_q ? ID_MASK : GP_MASK;

  assign wr_fire  = fall_w && !start_w && !stop_w && state_q == ST_WDATA && byte_end;
  assign rd_done  = fall_w && !start_w && !stop_w && state_q == ST_RDATA && byte_end;
  assign ptr_load = fall_w && !start_w && !stop_w && state_q == ST_ADDR && byte_end && addr_ok;

  i2c_addr_ptr #(.AW(AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ptr_load),
    .load_val_i  (sr_q[AW-1:0]),
    .step_i      (wr_fire | rd_done),
    .wrap_mask_i (mask_w),
    .ptr_o       (ptr_w)
  );

  i2c_byte_bank #(.DEPTH(GP_DEPTH)) u_gp_bank (
    .clk_i   (clk_i),
    .we_i    (wr_fire & ~rgn_q),
    .waddr_i (ptr_w),
    .wdata_i (sr_q),
    .raddr_i (ptr_w),
    .rdata_o (gp_rd)
  );

  i2c_byte_bank #(.DEPTH(ID_DEPTH)) u_id_bank (
    .clk_i   (clk_i),
    .we_i    (wr_fire & rgn_q),
    .waddr_i (ptr_w[IAW-1:0]),
    .wdata_i (sr_q),
    .raddr_i (ptr_w[IAW-1:0]),
    .rdata_o (id_rd)
  );

  assign rd_byte = rgn_q ? id_rd : gp_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      rgn_q   <= 1'b0;
    end else if (start_w) begin
      state_q <= ST_CTRL;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_w) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (rise_w) begin
      case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          sr_q  <= {sr_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end
        ST_RDATA: cnt_q <= cnt_q + 4'd1;
        ST_RACK:  if (sda_i) state_q <= ST_IDLE; // master NACK
        default: ;
      endcase
    end else if (fall_w) begin
      case (state_q)
        ST_CTRL: if (byte_end) begin
          if (code_hit) begin
            oe_q    <= 1'b1;
            rw_q    <= sr_q[0];
            rgn_q   <= id_hit;
            state_q <= ST_ACK_CTRL;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ACK_CTRL: begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= rd_byte;
            oe_q    <= ~rd_byte[7];
            state_q <= ST_RDATA;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR: if (byte_end) begin
          if (addr_ok) begin
            oe_q    <= 1'b1;
            state_q <= ST_ACK_ADDR;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ACK_ADDR, ST_ACK_WDATA: begin
          oe_q    <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_WDATA;
        end
        ST_WDATA: if (byte_end) begin
          oe_q    <= 1'b1;
          state_q <= ST_ACK_WDATA;
        end
        ST_RDATA: begin
          if (byte_end) begin
            oe_q    <= 1'b0;
            state_q <= ST_RACK;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end
        ST_RACK: begin
          cnt_q   <= '0;
          tx_q    <= rd_byte;
          oe_q    <= ~rd_byte[7];
          state_q <= ST_RDATA;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q) && !$past(start_w) && !$past(stop_w)) |-> !$past(scl_i)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q); // R2
  AST_START_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (state_q == ST_CTRL && cnt_q == 4'd0)); // R10
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (state_q == ST_IDLE)); // R10
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_w && !start_w && !stop_w && state_q == ST_ADDR && byte_end && !addr_ok)
      |=> $stable(ptr_w)); // R4
endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [6:0] GP = 7'b1101111;
  localparam logic [6:0] ID = 7'b1010111;
  // [15] 1 = identity array, [13:8] start address, [3:0] byte count
  localparam logic [15:0] VEC [6] = '{16'h0501, 16'h0A04, 16'h3E05,
                                      16'h8604, 16'h3F01, 16'h8008};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int total = 0, bad = 0, r9_viol = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;
  logic [7:0] ref_gp [64];
  logic [7:0] ref_id [8];
  int exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_target u_i2c_mem_target (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  // R9: enable may move only while SCL is low
  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe != prev_oe && scl_m) r9_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic pulse(output logic s);
    wq(); scl_m = 1'b1; wq(); s = sda_line; scl_m = 1'b0;
  endtask
  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 0; i < n; i++) begin sda_m = b[7-i]; pulse(s); end
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    send_bits(b, 8); sda_m = 1'b1; pulse(s); ack = ~s;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin pulse(s); b[7-i] = s; end
    sda_m = ~mack; pulse(s); sda_m = 1'b1;
  endtask

  task automatic cur_read(input logic [6:0] code, output logic [7:0] b);
    logic a;
    bus_start(); send_byte({code, 1'b1}, a);
    chk("R5 read control ack", a, 1'b1);
    recv_byte(1'b0, b); bus_stop();
  endtask

  task automatic rand_seq(input logic [6:0] code, input logic [5:0] addr, input int n);
    logic a; logic [7:0] b; int m;
    m = (code == ID) ? 7 : 63;
    bus_start(); send_byte({code, 1'b0}, a); chk("R2 control ack", a, 1'b1);
    send_byte({2'b00, addr}, a); chk("R3 address ack", a, 1'b1);
    bus_start(); send_byte({code, 1'b1}, a); chk("R6 read control ack", a, 1'b1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, b);
      chk((code == ID) ? "R7/R8 id data" : "R7/R8 gp data", b,
          (code == ID) ? ref_id[(addr + k) & m] : ref_gp[(addr + k) & m]);
    end
    bus_stop();
    exp_ptr = (addr + n) & m;
    cur_read(code, b);
    chk("R6 pointer after read", b, (code == ID) ? ref_id[exp_ptr & 7] : ref_gp[exp_ptr]);
    exp_ptr = (exp_ptr + 1) & m;
  endtask

  initial begin
    logic a; logic [7:0] b;
    for (int i = 0; i < 64; i++) ref_gp[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 8; i++)  ref_id[i] = 8'hA0 ^ 8'(i * 3);
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1; wq();

    // R3 preload both arrays; R11 same addresses, separate data
    bus_start(); send_byte({GP, 1'b0}, a); chk("R2 gp code ack", a, 1'b1);
    send_byte(8'h00, a); chk("R3 address ack", a, 1'b1);
    for (int i = 0; i < 64; i++) begin
      send_byte(ref_gp[i], a);
      if (!a) chk("R3 data ack", a, 1'b1);
    end
    bus_stop();
    bus_start(); send_byte({ID, 1'b0}, a); chk("R2 id code ack", a, 1'b1);
    send_byte(8'h00, a);
    for (int i = 0; i < 8; i++) send_byte(ref_id[i], a);
    bus_stop();

    // R1 pointer cleared, contents kept
    rst_n = 1'b0; wq(); chk("R1 oe low in reset", sda_oe, 1'b0); rst_n = 1'b1; wq();
    cur_read(GP, b); chk("R1 pointer zero after reset", b, ref_gp[0]);
    cur_read(GP, b); chk("R5 current read advances", b, ref_gp[1]);
    exp_ptr = 2;

    for (int v = 0; v < 6; v++)
      rand_seq(VEC[v][15] ? ID : GP, VEC[v][13:8], int'(VEC[v][3:0]));
    // last vector leaves pointer at 1 (identity array 0..7 read, then one more)

    rand_seq(GP, 6'd20, 2); // pointer now 23
    // R11 same address, separate arrays
    rand_seq(ID, 6'd3, 1);  // pointer 5
    rand_seq(GP, 6'd3, 1);  // pointer 5
    chk("R11 arrays differ", ref_gp[3] != ref_id[3], 1'b1);

    // R2 unknown code ignored
    bus_start(); send_byte(8'hA1, a); chk("R2 foreign code no ack", a, 1'b0);
    recv_byte(1'b0, b); chk("R2 line released", b, 8'hFF);
    bus_stop();
    cur_read(GP, b); chk("R2 pointer untouched", b, ref_gp[5]); // pointer 6

    // R4 out-of-range addresses
    bus_start(); send_byte({GP, 1'b0}, a); send_byte(8'd64, a);
    chk("R4 gp address nack", a, 1'b0); bus_stop();
    cur_read(GP, b); chk("R4 pointer kept", b, ref_gp[6]); // pointer 7
    bus_start(); send_byte({ID, 1'b0}, a); send_byte(8'd8, a);
    chk("R4 id address nack", a, 1'b0);
    send_byte(8'h55, a); chk("R4 rest ignored", a, 1'b0); bus_stop();
    cur_read(GP, b); chk("R4 pointer kept after id", b, ref_gp[7]); // pointer 8

    // R10 start mid-address aborts
    bus_start(); send_byte({GP, 1'b0}, a); send_bits(8'h2A, 4);
    bus_start(); send_byte({GP, 1'b1}, a); chk("R10 restart ack", a, 1'b1);
    recv_byte(1'b0, b); bus_stop();
    chk("R10 restart data", b, ref_gp[8]); // pointer 9
    // R10 stop mid-data discards partial byte
    bus_start(); send_byte({GP, 1'b0}, a); send_byte(8'd9, a);
    send_bits(8'h00, 5); bus_stop();
    chk("R10 released after stop", sda_oe, 1'b0);
    cur_read(GP, b); chk("R10 partial byte not stored", b, ref_gp[9]);

    chk("R9 oe moved with SCL high", r9_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule